// File: doc/BRIEF.md
# Byte-Wide Serial Peripheral Interface Transceiver

This block moves one byte at a time over a four-wire serial peripheral bus and can act either as the bus master or as a bus slave, chosen by a control bit. A host reaches it through four small registers: control, status, data and clock/select. In master role a write to the data register starts an internal clock generator. The generator produces sixteen SCK edges at a rate set by a power-of-two divider, shifts the byte out on MOSI, captures MISO, and then stops. Slave select is never driven by the hardware on its own: it is a plain register bit that the host sets.

In slave role the block follows an external SCK. That SCK and the external select are brought into the system clock domain through two flip-flops, so the system clock must run at least four times faster than SCK. While select is high the block ignores SCK, holds its MISO driver disabled and still accepts a new transmit byte. Both roles share one shift register that swaps contents with the far end. At the end of each byte the received value is copied into a receive buffer, a done flag is set, and an interrupt may be raised.

Top module: `spi_xcvr`

## Requirements
- R1: After reset the status register (address 1) reads 0, irqOut is 0, misoOe is 0, sckOut is 0 and selOut is 0.
- R2: In master role the SCK full period in system clocks is 2^(rate+1), where rate is clock register bits [2:0] and a value of 7 acts as 6. Setting clock register bit 3 (double speed) halves the period, with a floor of 2.
- R3: A data-register write (address 2) in master role, with control bit 0 (enable) and bit 1 (master) set, produces exactly 16 SCK edges. SCK then rests at the CPOL level.
- R4: During a transfer each byte is exchanged full duplex: the written byte appears on MOSI, MISO is captured, and a data-register read returns the received byte from the receive buffer.
- R5: Control bit 3 set sends and receives least significant bit first. When it is clear, the most significant bit goes first.
- R6: Control bit 4 is CPOL (the SCK idle level) and bit 5 is CPHA. With CPHA=0, data is sampled on the edge leaving idle. With CPHA=1, it is sampled on the edge returning to idle, and the other edge shifts the next bit out.
- R7: Status bit 7 (done) is set when a byte completes. irqOut is high while done is set and control bit 2 (interrupt enable) is set.
- R8: Done and collision are cleared by a status read (rdEn) made while a flag is set, followed by any data-register access. An irqAck pulse also clears done.
- R9: A data-register write made while a byte is in progress sets status bit 6 (collision) and does not disturb the bits being sent or received.
- R10: selOut follows clock register bit 7 and changes only when that register is written.
- R11: In slave role (control bit 0 set, bit 1 clear), while selIn is high, misoOe is 0, SCK edges are ignored, and a data-register write loads the transmit byte.
- R12: In slave role with selIn low, misoOe is 1 and bits shift on the external SCK. Done is set after the eighth bit. Raising selIn part-way through a byte discards the partial byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (side effects only) |
| addr | input | 2 | Register address: 0 control, 1 status, 2 data, 3 clock/select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr (combinational) |
| irqOut | output | 1 | Interrupt request |
| irqAck | input | 1 | Interrupt acknowledge pulse |
| sckOut | output | 1 | Serial clock driven in master role |
| sckIn | input | 1 | Serial clock received in slave role |
| selOut | output | 1 | Host-controlled slave select output |
| selIn | input | 1 | Slave select input, active low |
| mosiOut | output | 1 | Master-out line driven in master role |
| mosiIn | input | 1 | Master-out line received in slave role |
| misoOut | output | 1 | Slave-out data value |
| misoOe | output | 1 | Slave-out driver enable |
| misoIn | input | 1 | Slave-out line received in master role |

## Verification
The master role is run against a bus model that tracks every SCK edge and swaps a byte with the design. Different data patterns, each divider setting, both bit orders and all four CPOL/CPHA pairs are tried. This separates a wrong sampling edge or a reversed bit order, which corrupts the exchanged bytes, from a wrong divider, which shows up only in the measured edge spacing. The slave role is driven with SCK pulses first while deselected and then while selected. A byte split at the seventh bit shows whether the deselected edges were counted. An aborted three-bit burst followed by a full byte shows whether the partial byte was thrown away.

// File: rtl/spi_xcvr_pkg.sv
package spi_xcvr_pkg;

  // Register addresses seen by the host
  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_STAT = 2'd1,
    REG_DATA = 2'd2,
    REG_CLK  = 2'd3
  } regAddr_t;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic load;    // take a new byte from the host
    logic drive;   // present the next outgoing bit
    logic sample;  // shift one incoming bit in
    logic finish;  // byte complete: copy to receive buffer
  } dpStrobe_t;

endpackage

// File: rtl/spi_dpath.sv
module spi_dpath
  import spi_xcvr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic              lsbFirst,
  input  logic [DATA_W-1:0] loadData,
  input  logic              inBit,
  output logic              txBit,
  output logic [DATA_W-1:0] rxBuf
);

  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] shifted;
  logic [DATA_W-1:0] capture;
  logic              loadBit;
  logic              nextBit;

  always_comb begin
    if (lsbFirst) begin
      shifted = {inBit, shiftReg[DATA_W-1:1]};
      loadBit = loadData[0];
      nextBit = shiftReg[0];
    end else begin
      shifted = {shiftReg[DATA_W-2:0], inBit};
      loadBit = loadData[DATA_W-1];
      nextBit = shiftReg[DATA_W-1];
    end
    capture = strb.sample ? shifted : shiftReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      txBit    <= 1'b0;
    end else if (strb.load) begin
      shiftReg <= loadData;
      txBit    <= loadBit;
    end else begin
      if (strb.sample) shiftReg <= shifted;
      if (strb.drive)  txBit    <= nextBit;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rxBuf <= '0;
    else if (strb.finish) rxBuf <= capture;
  end

  // R9
  sr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.load && !strb.sample) |=> $stable(shiftReg));

endmodule

// File: rtl/spi_ctrl.sv
module spi_ctrl
  import spi_xcvr_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int MAX_DIV = 128,
  parameter int RATE_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [DATA_W-1:0] rxBuf,
  input  logic              irqAck,
  output logic              irqOut,
  input  logic              sckIn,
  input  logic              selIn,
  output logic              sckOut,
  output logic              selOut,
  output logic              misoOe,
  output logic              isMaster,
  output logic              lsbFirst,
  output dpStrobe_t         strb
);

  localparam int MAX_EXP  = $clog2(MAX_DIV);
  localparam int MAX_RATE = MAX_EXP - 1;
  localparam int HALF_W   = MAX_EXP;
  localparam int EDGE_W   = $clog2(2 * DATA_W);
  localparam int BIT_W    = $clog2(DATA_W);

  // Host registers
  logic [DATA_W-1:0] ctrlReg, clkReg;
  logic              enable, irqEn, cpol, cpha, dblSpeed;
  logic [RATE_W-1:0] rateSel, rateEff, halfExp;
  logic [HALF_W-1:0] halfLen;

  assign enable   = ctrlReg[0];
  assign isMaster = ctrlReg[1];
  assign irqEn    = ctrlReg[2];
  assign lsbFirst = ctrlReg[3];
  assign cpol     = ctrlReg[4];
  assign cpha     = ctrlReg[5];
  assign rateSel  = clkReg[RATE_W-1:0];
  assign dblSpeed = clkReg[RATE_W];
  assign selOut   = clkReg[DATA_W-1];

  regAddr_t regSel;
  logic     wrData, dataAccess, statRead;
  assign regSel     = regAddr_t'(addr);
  assign wrData     = wrEn && (regSel == REG_DATA);
  assign dataAccess = (wrEn || rdEn) && (regSel == REG_DATA);
  assign statRead   = rdEn && (regSel == REG_STAT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
      clkReg  <= '0;
    end else if (wrEn) begin
      if (regSel == REG_CTRL) ctrlReg <= wdata;
      if (regSel == REG_CLK)  clkReg  <= wdata;
    end
  end

  // Divider: half period is a power of two
  always_comb begin
    rateEff = (rateSel > RATE_W'(MAX_RATE)) ? RATE_W'(MAX_RATE) : rateSel;
    halfExp = (dblSpeed && rateEff != '0) ? rateEff - RATE_W'(1) : rateEff;
    halfLen = HALF_W'(1) << halfExp;
  end

  // Master sequencer
  logic              mBusy, sckReg, tick, mLead, mTrail, mLast;
  logic [HALF_W-1:0] divCnt;
  logic [EDGE_W-1:0] edgeCnt;
  logic              masterOn, slaveMode;

  assign masterOn  = enable && isMaster;
  assign slaveMode = enable && !isMaster;
  assign tick      = mBusy && (divCnt == halfLen - HALF_W'(1));
  assign mLead     = tick && !edgeCnt[0];
  assign mTrail    = tick && edgeCnt[0];
  assign mLast     = tick && (edgeCnt == EDGE_W'(2 * DATA_W - 1));

  // Slave synchronizers and edge detect
  logic             sckS1, sckS2, sckS3, selS1, selS2;
  logic             slvOn, sEdge, sLead, sTrail, sLast;
  logic [BIT_W-1:0] slvCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckS1 <= 1'b0; sckS2 <= 1'b0; sckS3 <= 1'b0;
      selS1 <= 1'b1; selS2 <= 1'b1;
    end else begin
      sckS1 <= sckIn; sckS2 <= sckS1; sckS3 <= sckS2;
      selS1 <= selIn; selS2 <= selS1;
    end
  end

  assign slvOn  = slaveMode && !selS2;
  assign sEdge  = slvOn && (sckS2 != sckS3);
  assign sLead  = sEdge && (sckS2 != cpol);
  assign sTrail = sEdge && (sckS2 == cpol);

  // Edge roles shared by both sides
  logic lead, trail, sampleEdge, driveEdge, busy, accept, collSet;
  assign lead       = isMaster ? mLead : sLead;
  assign trail      = isMaster ? mTrail : sTrail;
  assign sampleEdge = cpha ? trail : lead;
  assign driveEdge  = cpha ? lead : trail;
  assign sLast      = !isMaster && sampleEdge && (slvCnt == BIT_W'(DATA_W - 1));
  assign busy       = isMaster ? mBusy : (slvOn && slvCnt != '0);
  assign accept     = wrData && enable && !busy;
  assign collSet    = wrData && enable && busy;

  always_comb begin
    strb.load   = accept;
    strb.drive  = driveEdge;
    strb.sample = sampleEdge;
    strb.finish = isMaster ? mLast : sLast;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mBusy   <= 1'b0;
      divCnt  <= '0;
      edgeCnt <= '0;
      sckReg  <= 1'b0;
    end else if (!masterOn) begin
      mBusy <= 1'b0;
    end else if (accept) begin
      mBusy   <= 1'b1;
      divCnt  <= '0;
      edgeCnt <= '0;
      sckReg  <= cpol;
    end else if (mBusy) begin
      if (tick) begin
        divCnt  <= '0;
        sckReg  <= ~sckReg;
        edgeCnt <= edgeCnt + EDGE_W'(1);
        if (mLast) mBusy <= 1'b0;
      end else begin
        divCnt <= divCnt + HALF_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           slvCnt <= '0;
    else if (!slvOn)     slvCnt <= '0;
    else if (sampleEdge) slvCnt <= slvCnt + BIT_W'(1);
  end

  assign sckOut = (isMaster && mBusy) ? sckReg : cpol;
  assign misoOe = slaveMode && !selIn;

  // Status flags and clear handshake
  logic doneFlag, collFlag, armed, clrSeq;
  assign clrSeq = armed && dataAccess;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneFlag <= 1'b0;
      collFlag <= 1'b0;
      armed    <= 1'b0;
    end else begin
      if (strb.finish)           doneFlag <= 1'b1;
      else if (irqAck || clrSeq) doneFlag <= 1'b0;
      if (collSet)               collFlag <= 1'b1;
      else if (clrSeq)           collFlag <= 1'b0;
      if (irqAck || clrSeq)      armed    <= 1'b0;
      else if (statRead && (doneFlag || collFlag)) armed <= 1'b1;
    end
  end

  assign irqOut = doneFlag && irqEn;

  always_comb begin
    unique case (regSel)
      REG_CTRL: rdata = ctrlReg;
      REG_STAT: rdata = {doneFlag, collFlag, {(DATA_W-2){1'b0}}};
      REG_DATA: rdata = rxBuf;
      default:  rdata = clkReg;
    endcase
  end

  // R3
  done_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(doneFlag) && isMaster) |-> $past(mBusy));

  // R6
  sample_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isMaster && strb.sample && !wrEn) |=> (sckOut != $past(sckOut)));

  // R8
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqAck && !strb.finish) |=> !doneFlag);

  // R10
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && regSel == REG_CLK) |=> $stable(selOut));

  // R11
  desel_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (slaveMode && selS2) |=> (slvCnt == '0));

endmodule

// File: rtl/spi_xcvr.sv
module spi_xcvr
  import spi_xcvr_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int MAX_DIV = 128,
  parameter int RATE_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irqOut,
  input  logic              irqAck,
  output logic              sckOut,
  input  logic              sckIn,
  output logic              selOut,
  input  logic              selIn,
  output logic              mosiOut,
  input  logic              mosiIn,
  output logic              misoOut,
  output logic              misoOe,
  input  logic              misoIn
);

  dpStrobe_t         strb;
  logic              isMaster, lsbFirst, txBit, inBit;
  logic [DATA_W-1:0] rxBuf;

  spi_ctrl #(.DATA_W(DATA_W), .MAX_DIV(MAX_DIV), .RATE_W(RATE_W)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rxBuf(rxBuf), .irqAck(irqAck),
    .irqOut(irqOut), .sckIn(sckIn), .selIn(selIn), .sckOut(sckOut),
    .selOut(selOut), .misoOe(misoOe), .isMaster(isMaster),
    .lsbFirst(lsbFirst), .strb(strb)
  );

  assign inBit = isMaster ? misoIn : mosiIn;

  spi_dpath #(.DATA_W(DATA_W)) uDpath (
    .clk(clk), .rstN(rstN), .strb(strb), .lsbFirst(lsbFirst),
    .loadData(wdata), .inBit(inBit), .txBit(txBit), .rxBuf(rxBuf)
  );

  assign mosiOut = isMaster ? txBit : 1'b0;
  assign misoOut = txBit;

endmodule

// File: tb/spi_xcvr_test.sv
module spi_xcvr_test;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0, rdEn = 1'b0, irqAck = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       irqOut, sckOut, selOut, mosiOut, misoOut, misoOe;
  logic       sckIn = 1'b0, selIn = 1'b1, mosiIn = 1'b0;
  logic       misoIn = 1'b0;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  spi_xcvr uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irqOut(irqOut), .irqAck(irqAck),
    .sckOut(sckOut), .sckIn(sckIn), .selOut(selOut), .selIn(selIn),
    .mosiOut(mosiOut), .mosiIn(mosiIn), .misoOut(misoOut),
    .misoOe(misoOe), .misoIn(misoIn)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic checkEq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic readReg(input logic [1:0] a, input logic strobe, output logic [7:0] d);
    @(negedge clk); addr = a; rdEn = strobe;
    #1 d = rdata;
    @(negedge clk); rdEn = 1'b0;
  endtask

  // Bus model acting as the far-end slave for master tests
  logic [7:0] mTx = 8'd0, mRx = 8'd0;
  logic       mCpol = 1'b0, mCpha = 1'b0, mLsb = 1'b0;
  logic       prevSck = 1'b0, lead = 1'b0;
  int armReq = 0, armSeen = 0;
  int sIdx = 0, dIdx = 0, mEdges = 0, lastEdge = 0, minGap = 0, maxGap = 0;

  function automatic logic bitOf(logic [7:0] b, int i, logic lsb);
    return lsb ? b[i] : b[7-i];
  endfunction

  always @(negedge clk) begin
    if (armReq != armSeen) begin
      armSeen = armReq;
      sIdx = 0; mEdges = 0; minGap = 1000000; maxGap = 0; mRx = 8'd0;
      prevSck = sckOut;
      if (!mCpha) begin misoIn = bitOf(mTx, 0, mLsb); dIdx = 1; end
      else dIdx = 0;
    end else if (sckOut !== prevSck) begin
      if (mEdges > 0) begin
        if (cyc - lastEdge < minGap) minGap = cyc - lastEdge;
        if (cyc - lastEdge > maxGap) maxGap = cyc - lastEdge;
      end
      lastEdge = cyc;
      mEdges++;
      lead = (sckOut != mCpol);
      if (lead != mCpha) begin
        if (sIdx < 8) mRx[mLsb ? sIdx : 7 - sIdx] = mosiOut;
        sIdx++;
      end else begin
        if (dIdx < 8) misoIn = bitOf(mTx, dIdx, mLsb);
        dIdx++;
      end
      prevSck = sckOut;
    end
  end

  function automatic int expHalf(logic [7:0] c);
    int r = int'(c[2:0]);
    if (r > 6) r = 6;
    if (c[3] && r > 0) r--;
    return 1 << r;
  endfunction

  task automatic waitDone(output bit ok);
    logic [7:0] s;
    ok = 1'b0;
    for (int i = 0; i < 6000 && !ok; i++) begin
      readReg(2'd1, 1'b0, s);
      if (s[7]) ok = 1'b1;
    end
  endtask

  task automatic masterXfer(input logic [7:0] ctrlV, input logic [7:0] clkV,
                            input logic [7:0] txB, input logic [7:0] slvB,
                            input bit useAck, input string req);
    bit ok;
    logic [7:0] s, d;
    writeReg(2'd0, ctrlV);
    writeReg(2'd3, clkV);
    mCpol = ctrlV[4]; mCpha = ctrlV[5]; mLsb = ctrlV[3]; mTx = slvB;
    armReq++;
    repeat (2) @(negedge clk);
    writeReg(2'd2, txB);
    waitDone(ok);
    checkEq("R7", "done seen", int'(ok), 1);
    repeat (2) @(negedge clk);
    checkEq("R7", "irq", int'(irqOut), int'(ctrlV[2]));
    readReg(2'd1, !useAck, s);
    checkEq("R7", "status", int'(s), 8'h80);
    checkEq(req, "bits on mosi", int'(mRx), int'(txB));
    checkEq("R3", "edge count", mEdges, 16);
    checkEq("R3", "sck idle", int'(sckOut), int'(ctrlV[4]));
    checkEq("R2", "min half period", minGap, expHalf(clkV));
    checkEq("R2", "max half period", maxGap, expHalf(clkV));
    if (useAck) begin
      @(negedge clk); irqAck = 1'b1;
      @(negedge clk); irqAck = 1'b0;
      readReg(2'd2, 1'b0, d);
    end else begin
      readReg(2'd2, 1'b1, d);
    end
    checkEq(req, "received byte", int'(d), int'(slvB));
    readReg(2'd1, 1'b0, s);
    checkEq("R8", "status after clear", int'(s), 0);
    checkEq("R8", "irq after clear", int'(irqOut), 0);
  endtask

  task automatic slaveShift(input logic [7:0] inB, input int first, input int cnt,
                            inout logic [7:0] got);
    for (int i = first; i < first + cnt; i++) begin
      @(negedge clk); mosiIn = inB[7-i];
      repeat (4) @(negedge clk);
      got[7-i] = misoOut;
      sckIn = 1'b1;
      repeat (8) @(negedge clk);
      sckIn = 1'b0;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic testReset();
    logic [7:0] s;
    readReg(2'd1, 1'b0, s);
    checkEq("R1", "status", int'(s), 0);
    checkEq("R1", "irq", int'(irqOut), 0);
    checkEq("R1", "misoOe", int'(misoOe), 0);
    checkEq("R1", "sckOut", int'(sckOut), 0);
    checkEq("R1", "selOut", int'(selOut), 0);
  endtask

  task automatic testMasterBasic();
    masterXfer(8'h07, 8'h00, 8'hA5, 8'h3C, 1'b0, "R4");
    masterXfer(8'h07, 8'h01, 8'h0F, 8'hE1, 1'b0, "R4");
  endtask

  task automatic testDividers();
    masterXfer(8'h07, 8'h03, 8'h96, 8'h69, 1'b0, "R2");
    masterXfer(8'h07, 8'h0B, 8'h12, 8'h34, 1'b0, "R2");
    masterXfer(8'h07, 8'h08, 8'hFE, 8'h01, 1'b0, "R2");
    masterXfer(8'h07, 8'h0E, 8'h55, 8'hAA, 1'b0, "R2");
    masterXfer(8'h07, 8'h07, 8'hC3, 8'h5A, 1'b0, "R2");
  endtask

  task automatic testModesOrder();
    masterXfer(8'h0F, 8'h01, 8'h01, 8'h80, 1'b0, "R5");
    masterXfer(8'h27, 8'h01, 8'hB4, 8'h2D, 1'b0, "R6");
    masterXfer(8'h17, 8'h01, 8'h4B, 8'hD2, 1'b0, "R6");
    masterXfer(8'h37, 8'h02, 8'h81, 8'h7E, 1'b0, "R6");
    masterXfer(8'h3F, 8'h02, 8'h06, 8'h60, 1'b0, "R5");
  endtask

  task automatic testIrqAck();
    masterXfer(8'h03, 8'h00, 8'h77, 8'h88, 1'b1, "R8");
    masterXfer(8'h07, 8'h00, 8'h99, 8'h11, 1'b1, "R8");
  endtask

  task automatic testCollision();
    bit ok;
    logic [7:0] s, d;
    writeReg(2'd0, 8'h07);
    writeReg(2'd3, 8'h03);
    mCpol = 1'b0; mCpha = 1'b0; mLsb = 1'b0; mTx = 8'h24;
    armReq++;
    repeat (2) @(negedge clk);
    writeReg(2'd2, 8'h5A);
    repeat (20) @(negedge clk);
    writeReg(2'd2, 8'hFF);
    waitDone(ok);
    repeat (2) @(negedge clk);
    readReg(2'd1, 1'b1, s);
    checkEq("R9", "status with collision", int'(s), 8'hC0);
    checkEq("R9", "bits on mosi", int'(mRx), 8'h5A);
    checkEq("R9", "edge count", mEdges, 16);
    readReg(2'd2, 1'b1, d);
    checkEq("R9", "received byte", int'(d), 8'h24);
    readReg(2'd1, 1'b0, s);
    checkEq("R8", "status after clear", int'(s), 0);
  endtask

  task automatic testSelect();
    masterXfer(8'h07, 8'h81, 8'h3E, 8'hC1, 1'b0, "R4");
    checkEq("R10", "selOut held high", int'(selOut), 1);
    writeReg(2'd3, 8'h01);
    checkEq("R10", "selOut low", int'(selOut), 0);
  endtask

  task automatic testSlave();
    logic [7:0] s, d, got;
    got = 8'd0;
    writeReg(2'd0, 8'h01);
    selIn = 1'b1;
    writeReg(2'd2, 8'h96);
    checkEq("R11", "misoOe deselected", int'(misoOe), 0);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); sckIn = 1'b1;
      repeat (4) @(negedge clk); sckIn = 1'b0;
      repeat (4) @(negedge clk);
    end
    readReg(2'd1, 1'b0, s);
    checkEq("R11", "no done while deselected", int'(s), 0);
    selIn = 1'b0;
    repeat (4) @(negedge clk);
    checkEq("R12", "misoOe selected", int'(misoOe), 1);
    slaveShift(8'h5A, 0, 7, got);
    readReg(2'd1, 1'b0, s);
    checkEq("R12", "no done after 7 bits", int'(s), 0);
    slaveShift(8'h5A, 7, 1, got);
    repeat (4) @(negedge clk);
    readReg(2'd1, 1'b1, s);
    checkEq("R12", "done after 8 bits", int'(s), 8'h80);
    checkEq("R11", "byte loaded while deselected", int'(got), 8'h96);
    readReg(2'd2, 1'b1, d);
    checkEq("R12", "slave received", int'(d), 8'h5A);
    selIn = 1'b1;
    repeat (4) @(negedge clk);
    // partial burst then deselect
    writeReg(2'd2, 8'hC3);
    selIn = 1'b0;
    repeat (4) @(negedge clk);
    slaveShift(8'hFF, 0, 3, got);
    selIn = 1'b1;
    repeat (6) @(negedge clk);
    readReg(2'd1, 1'b0, s);
    checkEq("R12", "no done after abort", int'(s), 0);
    writeReg(2'd2, 8'hC3);
    selIn = 1'b0;
    repeat (4) @(negedge clk);
    got = 8'd0;
    slaveShift(8'h81, 0, 8, got);
    repeat (4) @(negedge clk);
    readReg(2'd1, 1'b1, s);
    checkEq("R12", "done after fresh byte", int'(s), 8'h80);
    checkEq("R12", "slave sent after abort", int'(got), 8'hC3);
    readReg(2'd2, 1'b1, d);
    checkEq("R12", "slave received after abort", int'(d), 8'h81);
    selIn = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testReset();
    testMasterBasic();
    testDividers();
    testModesOrder();
    testIrqAck();
    testCollision();
    testSelect();
    testSlave();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule